// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that an in-order processor uses to enter and leave exception handlers. At each instruction boundary it takes one pending event. That event is a synchronous trap raised by the instruction just completed, a return-from-handler request, or an external interrupt that the current status word allows. The sequencer then runs a short, fixed series of memory transactions on a single-port memory interface.

On entry it pushes the saved program counter and then the status word onto a downward-growing stack. It then reads the handler address from a vector table that traps and interrupts share. The table starts at a base register that software can load. On return it pops the two words in the opposite order. At the end it presents the new program counter and status word to the core with load strobes.

Instruction execution, the core's register file and the memory itself are outside the block. The core stalls while `busy_o` is high and applies `pc_o` and `status_o` when `done_o` pulses.

Top module: `exc_seq`

## Requirements
- R1: An event is accepted only in a cycle where `boundary_i` is high and the sequencer is idle; requests held without a boundary cause no memory access and leave `busy_o` low.
- R2: On entry the sequencer writes the saved PC to address SP-4 and then writes the status word to SP-8. SP starts at 0x1000 after reset and ends 8 lower.
- R3: A trap saves `cur_pc_i` (the faulting instruction); an interrupt saves `next_pc_i` (the first instruction not yet started).
- R4: After the pushes the sequencer reads the word at base + 4 × vector and presents it as the new PC. The vector is the trap number (0–15) for a trap and 16 + the interrupt number for an interrupt.
- R5: Priority at one boundary is trap, then return request, then interrupt.
- R6: An interrupt is taken only while status bit 0 (interrupt enable) is set; when it is clear, the interrupt is ignored and a trap is still taken.
- R7: On entry the new status word equals the saved status word with bit 0 cleared and all other bits unchanged.
- R8: On return the sequencer reads the status word at SP and then the PC at SP+4, and SP rises by 8. The popped words become `status_o` and `pc_o`, so the interrupt-enable bit comes back from memory.
- R9: Each memory request holds its address, direction and write data until `mem_ready_i` is sampled high, for any number of wait cycles.
- R10: The table base resets to 0x100 and takes `base_d_i` on a clock where `base_we_i` is high; a later entry uses the new base.
- R11: `busy_o` rises in the cycle after acceptance and stays high through the final cycle. In that final cycle `done_o`, `pc_we_o` and `status_we_o` pulse together for one cycle, and `busy_o` is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Current instruction has completed |
| cur_pc_i | input | 32 | PC of the completed (or faulting) instruction |
| next_pc_i | input | 32 | PC of the next instruction |
| status_i | input | 32 | Current status word, bit 0 is interrupt enable |
| trap_req_i | input | 1 | Trap raised by the completed instruction |
| trap_num_i | input | 4 | Trap number |
| irq_req_i | input | 1 | External interrupt pending |
| irq_num_i | input | 4 | Interrupt number |
| rfi_req_i | input | 1 | Completed instruction requests return from handler |
| base_we_i | input | 1 | Load vector-table base |
| base_d_i | input | 32 | New vector-table base |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Current request completes this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, one cycle |
| pc_we_o | output | 1 | Load `pc_o` into the core |
| pc_o | output | 32 | New PC |
| status_we_o | output | 1 | Load `status_o` into the core |
| status_o | output | 32 | New status word |

## Verification
The bench starts with a lone interrupt under zero memory latency, which checks push order, stack addresses and the vector index in their simplest form. It then repeats entries and returns under random wait states, which tells a correct request hold apart from one that advances early. Nested entries followed by matched returns show whether the stack pointer moves correctly, because any wrong step shifts every later address. Simultaneous trap, return and interrupt requests, masked interrupts, and a vector base moved between events separate the priority order, the enable gating and the table indexing from one another.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_PC, S_PUSH_ST, S_FETCH, S_POP_ST, S_POP_PC, S_FINISH
  } seq_state_e;

  typedef enum logic [1:0] {C_NONE, C_TRAP, C_IRQ, C_RET} cause_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter import exc_seq_pkg::*; #(
  parameter int XLEN   = 32,
  parameter int NUM_W  = 4,
  parameter int IE_BIT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             boundary_i,
  input  logic             trap_req_i,
  input  logic [NUM_W-1:0] trap_num_i,
  input  logic             irq_req_i,
  input  logic [NUM_W-1:0] irq_num_i,
  input  logic             rfi_req_i,
  input  logic [XLEN-1:0]  status_i,
  input  logic [XLEN-1:0]  cur_pc_i,
  input  logic [XLEN-1:0]  next_pc_i,
  output cause_e           cause_o,
  output logic [NUM_W:0]   vec_num_o,
  output logic [XLEN-1:0]  save_pc_o
);
  always_comb begin
    cause_o = C_NONE;
    if (idle_i && boundary_i) begin
      if (trap_req_i)                         cause_o = C_TRAP;
      else if (rfi_req_i)                     cause_o = C_RET;
      else if (irq_req_i && status_i[IE_BIT]) cause_o = C_IRQ;
    end
  end

  // traps take the low half of the table, interrupts the upper half
  assign vec_num_o = trap_req_i ? {1'b0, trap_num_i} : {1'b1, irq_num_i};
  assign save_pc_o = trap_req_i ? cur_pc_i : next_pc_i;

  a_r6_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == C_IRQ) |-> status_i[IE_BIT] && !trap_req_i && !rfi_req_i);
endmodule

// File: rtl/exc_vec_base.sv
module exc_vec_base #(
  parameter int              XLEN      = 32,
  parameter bit              WRITABLE  = 1'b1,
  parameter logic [XLEN-1:0] RESET_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] base_o
);
  generate
    if (WRITABLE) begin : g_reg
      logic [XLEN-1:0] base_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   base_q <= RESET_VAL;
        else if (we_i) base_q <= d_i;
      end
      assign base_o = base_q;
    end else begin : g_fixed
      logic unused_w;
      assign unused_w = we_i ^ (^d_i);
      assign base_o   = RESET_VAL;
    end
  endgenerate
endmodule

// File: rtl/exc_sp_reg.sv
module exc_sp_reg #(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dec_i,
  input  logic            inc_i,
  output logic [XLEN-1:0] sp_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  logic [XLEN-1:0] sp_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= RESET_VAL;
    else if (dec_i)  sp_q <= sp_q - STEP;
    else if (inc_i)  sp_q <= sp_q + STEP;
  end
  assign sp_o = sp_q;

  a_r2_one_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i && inc_i));
  a_r8_word_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i || inc_i) |=> (sp_q == $past(sp_q) - STEP) || (sp_q == $past(sp_q) + STEP));
endmodule

// File: rtl/exc_seq.sv
module exc_seq import exc_seq_pkg::*; #(
  parameter int              XLEN          = 32,
  parameter int              NUM_W         = 4,
  parameter int              IE_BIT        = 0,
  parameter logic [XLEN-1:0] SP_RESET      = 32'h0000_1000,
  parameter logic [XLEN-1:0] BASE_RESET    = 32'h0000_0100,
  parameter bit              BASE_WRITABLE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic [XLEN-1:0]  cur_pc_i,
  input  logic [XLEN-1:0]  next_pc_i,
  input  logic [XLEN-1:0]  status_i,
  input  logic             trap_req_i,
  input  logic [NUM_W-1:0] trap_num_i,
  input  logic             irq_req_i,
  input  logic [NUM_W-1:0] irq_num_i,
  input  logic             rfi_req_i,
  input  logic             base_we_i,
  input  logic [XLEN-1:0]  base_d_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ready_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pc_we_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             status_we_o,
  output logic [XLEN-1:0]  status_o
);
  localparam int              VW    = NUM_W + 1;
  localparam int              WB    = $clog2(XLEN / 8);
  localparam logic [XLEN-1:0] STEP  = XLEN'(XLEN / 8);
  localparam logic [XLEN-1:0] IE_MK = XLEN'(1) << IE_BIT;

  seq_state_e      state_q, state_d;
  cause_e          cause;
  logic [VW-1:0]   vec_num, vec_q;
  logic [XLEN-1:0] save_pc, save_pc_q, save_st_q, new_pc_q, new_st_q;
  logic [XLEN-1:0] sp, base, vec_addr;
  logic            ret_q, idle, xfer, sp_dec, sp_inc;

  assign idle = (state_q == S_IDLE);
  assign xfer = mem_req_o && mem_ready_i;

  exc_arbiter #(.XLEN(XLEN), .NUM_W(NUM_W), .IE_BIT(IE_BIT)) u_arb (
    .clk_i, .rst_ni, .idle_i(idle), .boundary_i, .trap_req_i, .trap_num_i,
    .irq_req_i, .irq_num_i, .rfi_req_i, .status_i, .cur_pc_i, .next_pc_i,
    .cause_o(cause), .vec_num_o(vec_num), .save_pc_o(save_pc)
  );

  exc_vec_base #(.XLEN(XLEN), .WRITABLE(BASE_WRITABLE), .RESET_VAL(BASE_RESET)) u_base (
    .clk_i, .rst_ni, .we_i(base_we_i), .d_i(base_d_i), .base_o(base)
  );

  assign sp_dec = xfer && (state_q == S_PUSH_PC || state_q == S_PUSH_ST);
  assign sp_inc = xfer && (state_q == S_POP_ST  || state_q == S_POP_PC);

  exc_sp_reg #(.XLEN(XLEN), .RESET_VAL(SP_RESET)) u_sp (
    .clk_i, .rst_ni, .dec_i(sp_dec), .inc_i(sp_inc), .sp_o(sp)
  );

  assign vec_addr = base + ({{(XLEN-VW){1'b0}}, vec_q} << WB);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (cause == C_RET)       state_d = S_POP_ST;
        else if (cause != C_NONE) state_d = S_PUSH_PC;
      end
      S_PUSH_PC: if (xfer) state_d = S_PUSH_ST;
      S_PUSH_ST: if (xfer) state_d = S_FETCH;
      S_FETCH:   if (xfer) state_d = S_FINISH;
      S_POP_ST:  if (xfer) state_d = S_POP_PC;
      S_POP_PC:  if (xfer) state_d = S_FINISH;
      S_FINISH:  state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      vec_q     <= '0;
      save_pc_q <= '0;
      save_st_q <= '0;
      new_pc_q  <= '0;
      new_st_q  <= '0;
      ret_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idle && cause != C_NONE) begin
        vec_q     <= vec_num;
        save_pc_q <= save_pc;
        save_st_q <= status_i;
        ret_q     <= (cause == C_RET);
      end
      if (xfer) begin
        unique case (state_q)
          S_FETCH: begin
            new_pc_q <= mem_rdata_i;
            new_st_q <= save_st_q & ~IE_MK;
          end
          S_POP_ST: new_st_q <= mem_rdata_i;
          S_POP_PC: new_pc_q <= mem_rdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_PUSH_PC: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = sp - STEP; mem_wdata_o = save_pc_q;
      end
      S_PUSH_ST: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = sp - STEP; mem_wdata_o = save_st_q;
      end
      S_FETCH: begin
        mem_req_o = 1'b1; mem_addr_o = vec_addr;
      end
      S_POP_ST, S_POP_PC: begin
        mem_req_o = 1'b1; mem_addr_o = sp;
      end
      default: ;
    endcase
  end

  assign busy_o      = !idle;
  assign done_o      = (state_q == S_FINISH);
  assign pc_we_o     = done_o;
  assign status_we_o = done_o;
  assign pc_o        = new_pc_q;
  assign status_o    = new_st_q;

  a_r9_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r1_busy_from_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(boundary_i));
  a_r1_no_access_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  a_r11_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);
  a_r11_strobes_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pc_we_o && status_we_o && busy_o);
  a_r7_entry_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ret_q) |-> !status_o[IE_BIT]);
endmodule

// File: tb/exc_seq_tb_top.sv
module exc_seq_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boundary_i = 1'b0;
  logic [31:0] cur_pc_i = '0, next_pc_i = '0, status_i = '0;
  logic        trap_req_i = 1'b0, irq_req_i = 1'b0, rfi_req_i = 1'b0;
  logic [3:0]  trap_num_i = '0, irq_num_i = '0;
  logic        base_we_i = 1'b0;
  logic [31:0] base_d_i = '0;
  logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic        busy_o, done_o, pc_we_o, status_we_o;
  logic [31:0] pc_o, status_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  exc_seq dut_i (
    .clk_i, .rst_ni, .boundary_i, .cur_pc_i, .next_pc_i, .status_i,
    .trap_req_i, .trap_num_i, .irq_req_i, .irq_num_i, .rfi_req_i,
    .base_we_i, .base_d_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ready_i, .busy_o, .done_o, .pc_we_o, .pc_o,
    .status_we_o, .status_o
  );

  typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } txn_t;

  int          checks = 0, failures = 0;
  logic [31:0] mem_m [logic [31:0]];
  txn_t        exp_q [$];
  logic [31:0] exp_sp = 32'h1000, exp_base = 32'h100;
  bit          rand_lat = 0, seen = 0, mbusy = 0;
  int          wcnt = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tbl_word(input logic [31:0] b, input int i);
    return 32'h4000_0000 + (b << 4) + 32'(i * 4);
  endfunction

  // reference: busy follows acceptance at a boundary until the done cycle (R11, R1)
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mbusy <= 0;
    else if (!mbusy && boundary_i && (trap_req_i || rfi_req_i || (irq_req_i && status_i[0])))
      mbusy <= 1;
    else if (mbusy && done_o) mbusy <= 0;
  end

  // per-clock compare and memory responder (R2, R4, R8, R9)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (busy_o !== mbusy) chk(0, "R11", "busy per clock", 32'(busy_o), 32'(mbusy));
      if (mem_req_o) begin
        if (!seen) begin
          seen = 1;
          if (exp_q.size() == 0) chk(0, "R1", "unexpected request", mem_addr_o, '0);
          else begin
            chk(mem_we_o == exp_q[0].we && mem_addr_o == exp_q[0].addr,
                "R2", "request addr", mem_addr_o, exp_q[0].addr);
            if (exp_q[0].we)
              chk(mem_wdata_o == exp_q[0].data, "R3", "push data", mem_wdata_o, exp_q[0].data);
          end
        end else begin
          chk(mem_addr_o == exp_q[0].addr, "R9", "held addr", mem_addr_o, exp_q[0].addr);
        end
        if (wcnt == 0) begin
          mem_ready_i = 1;
          if (mem_we_o) mem_m[mem_addr_o] = mem_wdata_o;
          else mem_rdata_i = mem_m.exists(mem_addr_o) ? mem_m[mem_addr_o] : '0;
          if (exp_q.size() > 0) void'(exp_q.pop_front());
          seen = 0;
          wcnt = rand_lat ? $urandom_range(0, 3) : 0;
        end else begin
          mem_ready_i = 0;
          mem_rdata_i = 32'hdead_beef;
          wcnt--;
        end
      end else begin
        mem_ready_i = 0;
      end
    end
  end

  task automatic fire(input bit tr, input logic [3:0] tn, input bit ir, input logic [3:0] inum,
                      input bit rf, input logic [31:0] st, input logic [31:0] cpc,
                      input logic [31:0] npc, input string rq);
    logic [31:0] e_pc, e_st, va;
    int vec;
    bit take;
    take = tr || rf || (ir && st[0]);
    if (take && !rf || tr) begin
      vec = tr ? int'(tn) : 16 + int'(inum);
      va = exp_base + 32'(vec * 4);
      exp_q.push_back('{1'b1, exp_sp - 4, tr ? cpc : npc});
      exp_q.push_back('{1'b1, exp_sp - 8, st});
      exp_q.push_back('{1'b0, va, '0});
      exp_sp -= 8;
      e_pc = mem_m[va];
      e_st = st & ~32'h1;
    end else if (take) begin
      exp_q.push_back('{1'b0, exp_sp, '0});
      exp_q.push_back('{1'b0, exp_sp + 4, '0});
      e_st = mem_m[exp_sp];
      e_pc = mem_m[exp_sp + 4];
      exp_sp += 8;
    end
    boundary_i = 1; trap_req_i = tr; trap_num_i = tn; irq_req_i = ir; irq_num_i = inum;
    rfi_req_i = rf; status_i = st; cur_pc_i = cpc; next_pc_i = npc;
    @(negedge clk_i);
    boundary_i = 0; trap_req_i = 0; rfi_req_i = 0;
    if (!take) begin
      repeat (3) @(negedge clk_i);
      chk(!busy_o && !mem_req_o, rq, "event ignored", 32'(busy_o), 0);
      irq_req_i = 0;
      return;
    end
    irq_req_i = 0;
    chk(busy_o === 1'b1, "R11", "busy after accept", 32'(busy_o), 1);
    while (!done_o) @(negedge clk_i);
    chk(pc_we_o && status_we_o, "R11", "load strobes", {pc_we_o, status_we_o}, 2'b11);
    chk(pc_o == e_pc, rq, "new pc", pc_o, e_pc);
    chk(status_o == e_st, rq, "new status", status_o, e_st);
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R11", "idle after done", {busy_o, done_o}, 0);
    chk(exp_q.size() == 0, rq, "all transactions seen", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem_m[32'h100 + 32'(i*4)] = tbl_word(32'h100, i);
      mem_m[32'h200 + 32'(i*4)] = tbl_word(32'h200, i);
    end
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !mem_req_o && !done_o && !pc_we_o, "R11", "reset outputs",
        {busy_o, mem_req_o, done_o, pc_we_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R1: pending interrupt without boundary
    irq_req_i = 1; status_i = 32'h1; irq_num_i = 4'd7;
    repeat (5) @(negedge clk_i);
    chk(!busy_o && !mem_req_o, "R1", "no boundary no entry", 32'(busy_o), 0);
    irq_req_i = 0;
    // R3 R4 R7: interrupt at zero latency
    fire(0, 0, 1, 4'd3, 0, 32'hA5A5_0001, 32'h2000, 32'h2004, "R4");
    // R8: return restores enable
    fire(0, 0, 0, 0, 1, 32'h0, 32'h3000, 32'h3004, "R8");
    rand_lat = 1;
    // R3 R9: trap saves faulting pc under wait states
    fire(1, 4'd5, 0, 0, 0, 32'h0000_0F01, 32'h2100, 32'h2104, "R3");
    // R6: nested, enable clear, interrupt ignored
    fire(0, 0, 1, 4'd2, 0, 32'h0000_0F00, 32'h2200, 32'h2204, "R6");
    // R6: trap still taken with enable clear; R5 trap beats irq and return
    fire(1, 4'd1, 1, 4'd9, 1, 32'h0000_0010, 32'h2300, 32'h2304, "R5");
    // R5: return beats interrupt
    fire(0, 0, 1, 4'd4, 1, 32'h1, 32'h2400, 32'h2404, "R5");
    fire(0, 0, 0, 0, 1, 32'h0, 32'h2500, 32'h2504, "R8");
    // R10: move the base then enter with the top interrupt number
    base_we_i = 1; base_d_i = 32'h200;
    @(negedge clk_i);
    base_we_i = 0; exp_base = 32'h200;
    fire(0, 0, 1, 4'd15, 0, 32'h0000_7771, 32'h2600, 32'h2604, "R10");
    fire(1, 4'd15, 0, 0, 0, 32'h0000_0002, 32'h2700, 32'h2704, "R4");
    for (int k = 0; k < 2; k++) fire(0, 0, 0, 0, 1, 32'h0, 32'h2800, 32'h2804, "R8");
    fire(0, 0, 1, 4'd0, 0, 32'h0000_0003, 32'h2900, 32'h2904, "R2");
    fire(0, 0, 0, 0, 1, 32'h0, 32'h2a00, 32'h2a04, "R8");
    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule